// File: doc/BRIEF.md
# Sliced Constant Carry-Save Multiplier

This block multiplies a signed data word by a signed coefficient fixed at elaboration time. The partial products of the coefficient bits are reduced by a carry-save array to a sum vector and a carry vector. A ripple-carry adder then merges the two vectors. Both the operand path and the merge adder are cut into staircase slices. Slice 0 covers the lowest `BASE_W` input bits, and each further slice adds `SLICE_W` bits. A per-slice enable mask chooses how much of the structure takes part in a multiply. With only the low slices enabled, the block gives exactly the result of a narrower signed multiplier. For example, with the defaults and two slices enabled, it acts as a 9-bit-input multiplier.

A multiply starts with a one-cycle `start` pulse. The block registers the masked operand. It then raises a one-cycle `done` strobe after a delay that grows with the number of active slices. A surrounding controller can use this to model completion time that depends on the data. Together with `done`, the block reports the active input width. Product bits above the active width are filled by sign extension, so `prod` is always a full-width two's complement value.

Top module: `cmul_sliced`

## Requirements
- R1: After reset, `done` is 0, `prod` is 0 and `width_out` is 0.
- R2: For a mask whose set bits form a contiguous run starting at bit 0, with m set bits (m ≥ 1), the active width is BASE_W + (m−1)·SLICE_W. `prod` at `done` equals the low active-width bits of `din`, read as a signed number, times COEF.
- R3: Input bits at or above the active width have no effect on `prod`.
- R4: A mask that is not such a contiguous run from bit 0 is treated as all slices enabled, giving the full input width.
- R5: An all-zero mask gives `prod` = 0 and `width_out` = 0, with `done` one cycle after `start`.
- R6: `done` is a one-cycle pulse. It rises max(m,1) clock cycles after the cycle in which `start` was accepted.
- R7: A `start` that arrives while a multiply is in flight and `done` is low is ignored. The running operation, its `prod` and its `width_out` are unchanged.
- R8: A `start` in the same cycle as `done` is accepted. `prod` and `width_out` keep the finishing result during that cycle.
- R9: Whenever `done` is high, the bits of `prod` above bit (active width + COEF_W − 1) all equal that bit.
- R10: `width_out`, valid with `done`, gives the active input width of the operation that is completing. It is 0 or BASE_W + k·SLICE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a multiply when the block is idle or finishing |
| din | input | IN_W | Signed operand, low bits used per active width |
| mask | input | N_SLICES | Slice enables, bit 0 = lowest slice |
| prod | output | P_W | Signed product, sign-extended to full width |
| done | output | 1 | One-cycle result strobe |
| width_out | output | WID_W | Active input width of the current result |

## Verification
The completion of one multiply and the acceptance of the next can happen in the same cycle. The bench provokes this by issuing every queued start exactly in the cycle its predecessor's `done` is due. The monitor then checks that the finishing product, width and latency still belong to the old item, and that the new item finishes after its own slice-count delay. A start that lands mid-flight, away from a `done` cycle, is also driven with a different operand and mask. The bench confirms that neither `width_out` nor the pending product moves.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

   // true when set bits form one run starting at bit 0 (zero included)
   function automatic logic is_thermo(input logic [31:0] m);
      return ((m & (m + 32'd1)) == 32'd0);
   endfunction

   function automatic int unsigned count_set(input logic [31:0] m);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 32; i++) n += 32'(m[i]);
      return n;
   endfunction

   function automatic int unsigned span_width(input int unsigned cnt,
                                              input int unsigned base,
                                              input int unsigned step);
      return (cnt == 0) ? 0 : base + (cnt - 1) * step;
   endfunction

endpackage

// File: rtl/cmul_operand_stage.sv
module cmul_operand_stage #(
   parameter int N_SLICES = 4,
   parameter int BASE_W   = 5,
   parameter int SLICE_W  = 4,
   parameter int IN_W     = 17,
   parameter int P_W      = 25,
   parameter int WID_W    = 5,
   parameter int CNT_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [IN_W-1:0]     din,
   input  logic [N_SLICES-1:0] mask,
   output logic [P_W-1:0]      op_q,
   output logic [WID_W-1:0]    width_q,
   output logic [N_SLICES-1:0] seg_en_q,
   output logic [CNT_W-1:0]    n_act_c
);
   import cmul_pkg::*;

   logic [N_SLICES-1:0] eff_mask;
   logic [IN_W-1:0]     lane_mask;
   logic [IN_W-1:0]     masked;
   logic [P_W-1:0]      ext;
   logic                sgn;
   int unsigned         n_act;
   int unsigned         aw;

   assign eff_mask = is_thermo(32'(mask)) ? mask : '1;

   for (genvar k = 0; k < N_SLICES; k++) begin : g_lane
      localparam int LO = (k == 0) ? 0 : BASE_W + (k - 1) * SLICE_W;
      localparam int W  = (k == 0) ? BASE_W : SLICE_W;
      assign lane_mask[LO +: W] = {W{eff_mask[k]}};
   end

   always_comb begin
      n_act  = count_set(32'(eff_mask));
      aw     = span_width(n_act, BASE_W, SLICE_W);
      masked = din & lane_mask;
      sgn    = 1'b0;
      for (int j = 0; j < IN_W; j++)
         if (32'(j) + 32'd1 == aw) sgn = masked[j];
      ext = {P_W{sgn}};
      for (int j = 0; j < IN_W; j++)
         if (32'(j) < aw) ext[j] = masked[j];
   end

   assign n_act_c = CNT_W'(n_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= '0;
         width_q  <= '0;
         seg_en_q <= '0;
      end else if (load) begin
         op_q     <= ext;
         width_q  <= WID_W'(aw);
         seg_en_q <= eff_mask;
      end
   end

   assert_width_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (width_q == '0) ||
      ((32'(width_q) >= BASE_W) && (32'(width_q) <= IN_W) &&
       (((32'(width_q) - BASE_W) % SLICE_W) == 0)))
      else $error("width_q holds an unreachable width");

endmodule

// File: rtl/cmul_csa_array.sv
module cmul_csa_array #(
   parameter int P_W    = 25,
   parameter int COEF_W = 8,
   parameter int COEF   = -91
) (
   input  logic [P_W-1:0] a,
   output logic [P_W-1:0] sum_v,
   output logic [P_W-1:0] carry_v
);
   localparam int ROWS = COEF_W + 1;
   localparam logic [COEF_W-1:0] CB = COEF_W'(COEF);

   logic [P_W-1:0] row [ROWS];
   logic [P_W-1:0] s_v [1:ROWS-1];
   logic [P_W-1:0] c_v [1:ROWS-1];

   // positive-weight rows
   for (genvar i = 0; i < COEF_W - 1; i++) begin : g_row
      assign row[i] = CB[i] ? (a << i) : '0;
   end
   // sign row of the coefficient is subtracted: invert plus one
   assign row[COEF_W-1] = CB[COEF_W-1] ? ~(a << (COEF_W - 1)) : '0;
   assign row[COEF_W]   = CB[COEF_W-1] ? P_W'(1) : '0;

   assign s_v[1] = row[0];
   assign c_v[1] = row[1];

   for (genvar k = 2; k < ROWS; k++) begin : g_csa
      assign s_v[k] = s_v[k-1] ^ c_v[k-1] ^ row[k];
      assign c_v[k] = ((s_v[k-1] & c_v[k-1]) |
                       (s_v[k-1] & row[k])   |
                       (c_v[k-1] & row[k])) << 1;
   end

   assign sum_v   = s_v[ROWS-1];
   assign carry_v = c_v[ROWS-1];

endmodule

// File: rtl/cmul_merge_adder.sv
module cmul_merge_adder #(
   parameter int N_SLICES = 4,
   parameter int BASE_W   = 5,
   parameter int SLICE_W  = 4,
   parameter int COEF_W   = 8,
   parameter int P_W      = 25
) (
   input  logic [P_W-1:0]      x,
   input  logic [P_W-1:0]      y,
   input  logic [N_SLICES-1:0] seg_en,
   output logic [P_W-1:0]      sum
);
   logic [P_W-1:0] raw;
   logic [P_W:0]   cy;
   logic           fill;

   assign cy[0] = 1'b0;

   for (genvar k = 0; k < N_SLICES; k++) begin : g_seg
      localparam int LO = (k == 0) ? 0 : BASE_W + COEF_W + (k - 1) * SLICE_W;
      localparam int W  = (k == 0) ? BASE_W + COEF_W : SLICE_W;
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic cin;
         if (b == 0 && k > 0) begin : g_gate
            assign cin = seg_en[k] & cy[LO];
         end else begin : g_pass
            assign cin = cy[LO+b];
         end
         assign raw[LO+b]  = x[LO+b] ^ y[LO+b] ^ cin;
         assign cy[LO+b+1] = (x[LO+b] & y[LO+b]) | (cin & (x[LO+b] ^ y[LO+b]));
      end
      assign sum[LO +: W] = seg_en[k] ? raw[LO +: W] : {W{fill}};
   end

   // top bit of the highest enabled segment extends upwards
   always_comb begin
      fill = 1'b0;
      for (int k = 0; k < N_SLICES; k++) begin
         if (seg_en[k])
            fill = raw[(k == 0) ? (BASE_W + COEF_W - 1)
                                : (BASE_W + COEF_W + k * SLICE_W - 1)];
      end
   end

endmodule

// File: rtl/cmul_done_timer.sv
module cmul_done_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] n_act,
   output logic             accept,
   output logic             done,
   output logic             busy
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lat;

   assign done   = (cnt == CNT_W'(1));
   assign busy   = (cnt != '0);
   assign accept = start && (!busy || done);
   assign lat    = (n_act == '0) ? CNT_W'(1) : n_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (accept)   cnt <= lat;
      else if (busy)     cnt <= cnt - CNT_W'(1);
   end

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done)
      else $error("done held longer than one cycle");

endmodule

// File: rtl/cmul_sliced.sv
module cmul_sliced #(
   parameter int N_SLICES = 4,
   parameter int BASE_W   = 5,
   parameter int SLICE_W  = 4,
   parameter int COEF_W   = 8,
   parameter int COEF     = -91,
   localparam int IN_W    = BASE_W + (N_SLICES - 1) * SLICE_W,
   localparam int P_W     = IN_W + COEF_W,
   localparam int WID_W   = $clog2(IN_W + 1),
   localparam int CNT_W   = $clog2(N_SLICES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [IN_W-1:0]     din,
   input  logic [N_SLICES-1:0] mask,
   output logic [P_W-1:0]      prod,
   output logic                done,
   output logic [WID_W-1:0]    width_out
);
   if (N_SLICES < 1 || N_SLICES > 31) begin : g_bad_slices
      $error("N_SLICES must lie in 1..31");
   end
   if (BASE_W < 1 || SLICE_W < 1) begin : g_bad_width
      $error("slice widths must be positive");
   end
   if (COEF_W < 2 || COEF_W > 32) begin : g_bad_coef_w
      $error("COEF_W must lie in 2..32");
   end
   if (COEF_W < 32) begin : g_coef_range
      if (COEF < -(2 ** (COEF_W - 1)) || COEF >= 2 ** (COEF_W - 1)) begin : g_bad_coef
         $error("COEF does not fit in COEF_W signed bits");
      end
   end

   logic                accept;
   logic                busy;
   logic [CNT_W-1:0]    n_act;
   logic [P_W-1:0]      op_q;
   logic [N_SLICES-1:0] seg_en;
   logic [P_W-1:0]      sum_v;
   logic [P_W-1:0]      carry_v;

   cmul_done_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .n_act(n_act),
      .accept(accept), .done(done), .busy(busy));

   cmul_operand_stage #(
      .N_SLICES(N_SLICES), .BASE_W(BASE_W), .SLICE_W(SLICE_W),
      .IN_W(IN_W), .P_W(P_W), .WID_W(WID_W), .CNT_W(CNT_W)
   ) u_operand (
      .clk(clk), .rst_n(rst_n), .load(accept), .din(din), .mask(mask),
      .op_q(op_q), .width_q(width_out), .seg_en_q(seg_en), .n_act_c(n_act));

   cmul_csa_array #(.P_W(P_W), .COEF_W(COEF_W), .COEF(COEF)) u_array (
      .a(op_q), .sum_v(sum_v), .carry_v(carry_v));

   cmul_merge_adder #(
      .N_SLICES(N_SLICES), .BASE_W(BASE_W), .SLICE_W(SLICE_W),
      .COEF_W(COEF_W), .P_W(P_W)
   ) u_merge (
      .x(sum_v), .y(carry_v), .seg_en(seg_en), .sum(prod));

   logic signed [P_W-1:0] prod_top;
   assign prod_top = $signed(prod) >>> (32'(width_out) + COEF_W - 1);

   assert_sign_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && width_out != '0) |-> (prod_top == '0 || prod_top == '1))
      else $error("product not sign-extended above active width");

   assert_zero_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && width_out == '0) |-> (prod == '0))
      else $error("zero-slice result is not zero");

   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> ($stable(width_out) && $stable(prod)))
      else $error("start taken while a multiply was in flight");

endmodule

// File: tb/cmul_sliced_bench.sv
module cmul_sliced_bench;
   localparam int N      = 4;
   localparam int BASE_W = 5;
   localparam int SLICE_W = 4;
   localparam int COEF_W = 8;
   localparam longint COEF = -91;
   localparam int IN_W   = BASE_W + (N - 1) * SLICE_W;
   localparam int P_W    = IN_W + COEF_W;
   localparam int WID_W  = $clog2(IN_W + 1);

   typedef struct {
      longint prod;
      int     width;
      longint acc;
      int     lat;
      string  tag;
   } exp_t;

   logic clk = 0;
   logic rst_n = 0;
   logic start_i = 0;
   logic [IN_W-1:0] din_i = '0;
   logic [N-1:0] mask_i = '0;
   logic [P_W-1:0] prod;
   logic done;
   logic [WID_W-1:0] width_out;

   exp_t q[$];
   int errors = 0;
   int checks = 0;
   longint cyc = 0;
   longint busy_until = 0;
   bit finished = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cmul_sliced u_cmul_sliced (
      .clk(clk), .rst_n(rst_n), .start(start_i), .din(din_i), .mask(mask_i),
      .prod(prod), .done(done), .width_out(width_out));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_count(input logic [N-1:0] m);
      bit seen_zero = 0;
      bit thermo = 1;
      int n = 0;
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            if (seen_zero) thermo = 0;
            n++;
         end else seen_zero = 1;
      end
      return thermo ? n : N;
   endfunction

   function automatic longint model_prod(input logic [IN_W-1:0] d, input int aw);
      longint v;
      if (aw == 0) return 0;
      v = longint'(d) & ((longint'(1) << aw) - 1);
      if (v[aw-1]) v = v - (longint'(1) << aw);
      return v * COEF;
   endfunction

   task automatic send(input logic [N-1:0] m, input logic [IN_W-1:0] d, input string tag);
      exp_t it;
      int n;
      while (cyc < busy_until) @(negedge clk);
      n = model_count(m);
      it.width = (n == 0) ? 0 : BASE_W + (n - 1) * SLICE_W;
      it.prod  = model_prod(d, it.width);
      it.lat   = (n == 0) ? 1 : n;
      it.acc   = cyc;
      it.tag   = tag;
      mask_i = m; din_i = d; start_i = 1;
      q.push_back(it);
      busy_until = cyc + it.lat;
      @(negedge clk);
      start_i = 0;
   endtask

   // start while in flight and not finishing: must be dropped
   task automatic poke_ignored(input int exp_w);
      mask_i = 4'b0001; din_i = '1; start_i = 1;
      @(negedge clk);
      start_i = 0;
      check(32'(width_out) == exp_w, "R7 width held", longint'(width_out), exp_w);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done) begin
            if (q.size() == 0) begin
               check(0, "R6 unexpected done", 1, 0);
            end else begin
               exp_t it;
               it = q.pop_front();
               check(longint'($signed(prod)) == it.prod, it.tag,
                     longint'($signed(prod)), it.prod);
               check(32'(width_out) == it.width, "R10 width",
                     longint'(width_out), it.width);
               check(cyc - it.acc == it.lat, "R6 latency", cyc - it.acc, it.lat);
            end
         end else if (q.size() > 0 && cyc >= q[0].acc + q[0].lat) begin
            check(0, "R6 missing done", 0, 1);
            void'(q.pop_front());
         end
      end
   end

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done == 0, "R1 done", longint'(done), 0);
      check(prod == '0, "R1 prod", longint'(prod), 0);
      check(width_out == '0, "R1 width", longint'(width_out), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      busy_until = cyc;

      // R2/R4/R5: sweep every mask, random words (upper garbage kept, R3)
      for (int m = 0; m < (1 << N); m++) begin
         int n;
         n = model_count(N'(m));
         for (int r = 0; r < 20; r++) begin
            string tg;
            if (m == 0) tg = "R5 zero mask";
            else if (n == N && m != (1 << N) - 1) tg = "R4 non-thermometer";
            else tg = "R2 product";
            send(N'(m), IN_W'($urandom), tg);
            if (r % 5 == 4) repeat (2) @(negedge clk);
         end
      end

      // R2 extremes per thermometer width with garbage above (R3)
      for (int m = 1; m <= N; m++) begin
         int aw;
         logic [IN_W-1:0] lo_v, hi_v;
         aw = BASE_W + (m - 1) * SLICE_W;
         lo_v = '1;
         lo_v = lo_v << aw;
         lo_v[aw-1] = 1'b1;
         hi_v = ~lo_v;
         hi_v = hi_v | (~('1 >> (IN_W - aw)));
         hi_v[aw-1] = 1'b0;
         send(N'((1 << m) - 1), lo_v, "R2 most negative");
         send(N'((1 << m) - 1), hi_v, "R2 most positive");
      end

      // R3: only garbage above a one-slice width, product must be zero
      send(4'b0001, 17'h1FFE0, "R3 upper bits ignored");
      // R2: two slices give a 9-bit multiply
      send(4'b0011, 17'h1F100, "R2 nine-bit -256");

      // R7: starts while busy are dropped
      send(4'b1111, 17'h0ABCD, "R7 busy run product");
      poke_ignored(IN_W);
      poke_ignored(IN_W);

      // R8: back-to-back starts in each done cycle
      send(4'b0011, 17'h00155, "R8 first");
      send(4'b0001, 17'h0001F, "R8 second");
      send(4'b0000, 17'h12345, "R8 zero after");
      send(4'b0111, 17'h1FFFF, "R8 last");

      repeat (N + 4) @(negedge clk);
      check(q.size() == 0, "R6 queue drained", q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule